// File: doc/BRIEF.md
# Decade Divider with Edge-Aligned Outputs

This block turns a 10 MHz reference clock into a family of square waves. It drives a full-rate output, a half-rate output at 5 MHz and a tenth-rate output at 1 MHz. It also drives one low-rate output whose frequency is a power of ten from 100 kHz down to 1 Hz, picked by a small select code. Every divided output has an even duty cycle. Every divided output is re-registered so that all rising edges land on the same reference clock edge.

The low-rate output comes from a chain of modulo-10 counters. A selector picks one counter. The selected level is captured once per 1 MHz period, then registered again on the reference clock. The half-rate and tenth-rate outputs go through two register stages, so they have the same two-cycle latency as the slow path. A new select code is adopted only when the slowest counter completes a period. At that instant every decade is starting a high phase, so a switch never produces a runt pulse.

The number of decades is a parameter (`NUM_DEC`, default 6, giving 100 kHz down to 1 Hz). Decade code d gives a period of 100·10^d reference cycles.

Top module: `decade_divider`

## Requirements
- R1: While `rst_n` is low, `o_f5`, `o_f1` and `o_dec` are 0, and they go to 0 asynchronously when `rst_n` falls.
- R2: `o_f10` equals the reference clock: it is high in the first half of each clock period and low in the second half.
- R3: Once running, `o_f5` is high for one cycle and low for one cycle, alternating. It is high exactly when the internal tenth-phase count is even.
- R4: Once running, `o_f1` is high for 5 cycles and low for 5 cycles.
- R5: With a valid code d (0 ≤ d < `NUM_DEC`) in effect, `o_dec` has a period of 100·10^d cycles and is high for the first half of it.
- R6: All counters start from zero. `o_f5`, `o_f1` and, for a valid code, `o_dec` each rise for the first time after the fourth rising clock edge following the release of `rst_n`. That edge count includes the two-stage reset synchronizer.
- R7: Every rising edge of `o_dec` coincides with a rising edge of `o_f1`. Every rising edge of `o_f1` coincides with a high on `o_f5`.
- R8: A change of `dec_sel` takes effect only at the boundary where the slowest decade starts a new period. The code present on the last cycle before that boundary governs the whole following period.
- R9: Codes at or above `NUM_DEC` (for example 3 when `NUM_DEC` = 3) hold `o_dec` low for the whole period they govern.
- R10: The code present on the first counting cycle after reset governs the first slowest-decade period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dec_sel | input | SEL_W (3) | Decade code: 0 = 100 kHz … NUM_DEC-1 = slowest; higher codes give a low output |
| o_f10 | output | 1 | Full-rate output (the reference itself) |
| o_f5 | output | 1 | Half-rate square wave |
| o_f1 | output | 1 | Tenth-rate square wave |
| o_dec | output | 1 | Selected low-rate decade square wave |

## Verification
Two functions can fall on the same cycle: the adoption of a new select code and a rising edge of the selected decade. The same applies to the rising edges of the fast outputs. The bench changes `dec_sel` in the middle of a slowest-decade period. It then checks, cycle by cycle, that the old decade continues up to the boundary and that the new one starts there on a shared rising edge with `o_f1` and `o_f5`. Codes that move into and out of the invalid range, and a reset in the middle of a run, show that the first period after reset and the hold-low case join the same edge grid.

// File: rtl/decade_divider_pkg.sv
package decade_divider_pkg;
  localparam int DIV_RATIO = 10;
  localparam int DIV_HALF  = DIV_RATIO / 2;
  localparam int DIV_CW    = $clog2(DIV_RATIO);
endpackage

// File: rtl/dd_reset_sync.sv
module dd_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_no = sync_q;
endmodule

// File: rtl/dd_decade_stage.sv
module dd_decade_stage
  import decade_divider_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic en,
  output logic hi,
  output logic term
);
  localparam logic [DIV_CW-1:0] LAST = DIV_CW'(DIV_RATIO - 1);
  localparam logic [DIV_CW-1:0] HALF = DIV_CW'(DIV_HALF);

  logic [DIV_CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign hi   = (cnt_q < HALF);
  assign term = (cnt_q == LAST);

  // R5: the counter wraps to zero after its last state
  a_r5_stage_wrap: assert property (@(posedge clk) disable iff (!rst_ni)
    (en && cnt_q == LAST) |=> (cnt_q == '0));
endmodule

// File: rtl/dd_fast_path.sv
module dd_fast_path
  import decade_divider_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  output logic [DIV_CW-1:0] phase,
  output logic              tick,
  output logic              ph0,
  output logic              o_f5,
  output logic              o_f1
);
  localparam logic [DIV_CW-1:0] LAST = DIV_CW'(DIV_RATIO - 1);
  localparam logic [DIV_CW-1:0] HALF = DIV_CW'(DIV_HALF);

  logic [DIV_CW-1:0] pre_q, pre_d;
  logic tog_q, tog_d;
  logic f5a_q, f5a_d, f5b_q;
  logic f1a_q, f1a_d, f1b_q;

  always_comb begin
    pre_d = (pre_q == LAST) ? '0 : pre_q + 1'b1;
    tog_d = ~tog_q;
    f5a_d = ~tog_q;
    f1a_d = (pre_q < HALF);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      tog_q <= 1'b0;
      f5a_q <= 1'b0;
      f5b_q <= 1'b0;
      f1a_q <= 1'b0;
      f1b_q <= 1'b0;
    end else begin
      pre_q <= pre_d;
      tog_q <= tog_d;
      f5a_q <= f5a_d;
      f5b_q <= f5a_q;
      f1a_q <= f1a_d;
      f1b_q <= f1a_q;
    end
  end

  assign phase = pre_q;
  assign tick  = (pre_q == LAST);
  assign ph0   = (pre_q == '0);
  assign o_f5  = f5b_q;
  assign o_f1  = f1b_q;

  // R3: half-rate high only on even phases
  a_r3_f5_even: assert property (@(posedge clk) disable iff (!rst_ni)
    o_f5 |-> (pre_q[0] == 1'b0));
  // R7: tenth-rate rises two cycles into the prescaler period
  a_r7_f1_phase: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(o_f1) |-> (pre_q == DIV_CW'(2)));
endmodule

// File: rtl/dd_slow_path.sv
module dd_slow_path
  import decade_divider_pkg::*;
#(
  parameter int NUM_DEC = 6,
  parameter int SEL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              tick,
  input  logic              ph0,
  input  logic [DIV_CW-1:0] phase,
  input  logic [SEL_W-1:0]  dec_sel,
  output logic              o_dec
);
  logic [NUM_DEC:0]   en;
  logic [NUM_DEC-1:0] stage_hi, stage_term;
  logic               boundary;
  logic               armed_q;
  logic [SEL_W-1:0]   sel_q, sel_d, idx;
  logic               raw;
  logic               mid_q, mid_d, out_q;

  assign en[0] = tick;

  for (genvar k = 0; k < NUM_DEC; k++) begin : g_stage
    dd_decade_stage u_stage (
      .clk   (clk),
      .rst_ni(rst_ni),
      .en    (en[k]),
      .hi    (stage_hi[k]),
      .term  (stage_term[k])
    );
    assign en[k+1] = en[k] & stage_term[k];
  end

  assign boundary = en[NUM_DEC];

  always_comb begin
    sel_d = sel_q;
    if (!armed_q || boundary) sel_d = dec_sel;
    idx = armed_q ? sel_q : dec_sel;
    raw = 1'b0;
    for (int k = 0; k < NUM_DEC; k++) begin
      if (int'(idx) == k) raw = stage_hi[k];
    end
    mid_d = ph0 ? raw : mid_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      sel_q   <= '0;
      mid_q   <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      sel_q   <= sel_d;
      mid_q   <= mid_d;
      out_q   <= mid_q;
    end
  end

  assign o_dec = out_q;

  // R8: the adopted code only moves at a slowest-decade boundary
  a_r8_sel_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (armed_q && !boundary) |=> $stable(sel_q));
  // R7: decade edges sit on the shared edge grid
  a_r7_dec_phase: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(o_dec) |-> (phase == DIV_CW'(2)));
endmodule

// File: rtl/decade_divider.sv
module decade_divider
  import decade_divider_pkg::*;
#(
  parameter int NUM_DEC = 6,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] dec_sel,
  output logic             o_f10,
  output logic             o_f5,
  output logic             o_f1,
  output logic             o_dec
);
  logic              rst_i;
  logic [DIV_CW-1:0] phase;
  logic              tick, ph0;

  dd_reset_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_no(rst_i)
  );

  dd_fast_path u_fast (
    .clk   (clk),
    .rst_ni(rst_i),
    .phase (phase),
    .tick  (tick),
    .ph0   (ph0),
    .o_f5  (o_f5),
    .o_f1  (o_f1)
  );

  dd_slow_path #(.NUM_DEC(NUM_DEC), .SEL_W(SEL_W)) u_slow (
    .clk    (clk),
    .rst_ni (rst_i),
    .tick   (tick),
    .ph0    (ph0),
    .phase  (phase),
    .dec_sel(dec_sel),
    .o_dec  (o_dec)
  );

  assign o_f10 = clk;

  // R7: a tenth-rate rise always meets a half-rate high
  a_r7_f1_on_f5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(o_f1) |-> o_f5);
  // R1: divided outputs stay low during reset
  a_r1_reset_low: assert property (@(posedge clk)
    !rst_n |-> (!o_f5 && !o_f1 && !o_dec));
endmodule

// File: tb/test_decade_divider.sv
module test_decade_divider;
  localparam int NDEC = 3;
  localparam int SW   = 3;
  localparam int PS   = 100 * (10 ** (NDEC - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SW-1:0] dec_sel = '0;
  logic o_f10, o_f5, o_f1, o_dec;

  int tests = 0;
  int fails = 0;
  int e = 0;
  bit done = 1'b0;
  int fsel [0:31];

  typedef struct {
    int    n;
    bit    in_rst;
    bit    f5, f1, dec;
    string tag;
  } exp_t;
  exp_t q[$];
  bit prev_dec = 1'b0, prev_f1 = 1'b0;

  always #4 clk = ~clk;

  decade_divider #(.NUM_DEC(NDEC), .SEL_W(SW)) i_decade_divider (
    .clk(clk), .rst_n(rst_n), .dec_sel(dec_sel),
    .o_f10(o_f10), .o_f5(o_f5), .o_f1(o_f1), .o_dec(o_dec)
  );

  always @(posedge clk) begin
    if (!rst_n) e <= 0;
    else        e <= e + 1;
  end

  task automatic check(input bit act, input bit exp_v, input string what, input string tag);
    tests++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at time %0t", tag, what, act, exp_v, $time);
    end
  endtask

  // predictor: driver-side expectation pushed once per cycle
  always @(negedge clk) begin
    exp_t it;
    int n, m, f, d, pd;
    n = e - 2;
    it.n = n;
    it.in_rst = !rst_n;
    it.f5 = 0; it.f1 = 0; it.dec = 0;
    it.tag = "R6";
    if (!rst_n) begin
      it.tag = "R1";
    end else if (n >= 0) begin
      if (n == 0) fsel[0] = int'(dec_sel);
      if ((n + 1) % PS == 0 && (n + 1) / PS < 32) fsel[(n + 1) / PS] = int'(dec_sel);
      if (n >= 2) begin
        m = n - 2;
        it.f1 = ((m % 10) < 5);
        it.f5 = (n % 2 == 0);
        f = m / PS;
        d = fsel[f];
        if (d >= NDEC) begin
          it.dec = 0;
          it.tag = "R9";
        end else begin
          pd = 100 * (10 ** d);
          it.dec = ((m % pd) < pd / 2);
          if (n <= 3) it.tag = "R6";
          else if (f == 0) it.tag = "R10";
          else if (fsel[f] != fsel[f-1] && (m % PS) < 100) it.tag = "R8";
          else it.tag = "R5";
        end
      end
    end
    q.push_back(it);
  end

  // monitor: pops expectations and compares against the ports
  always @(negedge clk) begin
    exp_t it;
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      check(o_f10, 1'b0, "o_f10 low phase", "R2");
      if (it.in_rst) begin
        check(o_f5, 1'b0, "o_f5 in reset", "R1");
        check(o_f1, 1'b0, "o_f1 in reset", "R1");
        check(o_dec, 1'b0, "o_dec in reset", "R1");
      end else begin
        check(o_f5, it.f5, "o_f5", (it.n <= 3) ? "R6" : "R3");
        check(o_f1, it.f1, "o_f1", (it.n <= 3) ? "R6" : "R4");
        check(o_dec, it.dec, "o_dec", it.tag);
        if (o_dec && !prev_dec) begin
          check(o_f1 && !prev_f1, 1'b1, "o_dec rise without o_f1 rise", "R7");
          check(o_f5, 1'b1, "o_dec rise without o_f5 high", "R7");
        end
      end
      prev_dec = o_dec;
      prev_f1  = o_f1;
    end
  end

  always @(posedge clk) begin
    #1;
    if (!done) check(o_f10, 1'b1, "o_f10 high phase", "R2");
  end

  task automatic at_state(input int t);
    while (e - 2 < t) @(negedge clk);
    #2;
  endtask

  initial begin
    fork
      begin
        #(200000 * 8);
        if (!done) begin
          tests++;
          fails++;
          $display("FAIL watchdog: actual timeout expected completion");
          done = 1'b1;
          $display("[TB] %0d tests run, %0d failed", tests, fails);
          $finish;
        end
      end
    join_none

    dec_sel = 3'd1;                  // R10: 10 kHz-equivalent in first period
    repeat (5) @(negedge clk);
    #2 rst_n = 1'b1;
    at_state(5000);  dec_sel = 3'd0; // R8: must wait for boundary at 10000
    at_state(15000); dec_sel = 3'd3; // R9: invalid code for third period
    at_state(25000); dec_sel = 3'd2; // slowest decade for fourth period
    at_state(35000); dec_sel = 3'd0;
    at_state(44000);
    rst_n = 1'b0;                    // R1: reset in mid-run
    dec_sel = 3'd2;
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    at_state(13000);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule